// File: doc/BRIEF.md
# Configurable Integer Minimum/Maximum Unit

This block returns either the smaller or the larger of two XLEN-bit register operands. A three-bit mode field picks between a comparison of the full doubleword and a comparison of the lower half-words only. It also picks signed or unsigned ordering, and whether the minimum or the maximum is kept. All eight combinations share one unsigned less-than comparator. Each operand is first conditioned: in word mode its low half is moved into the upper half and zeros fill the bits below it, and in signed mode its top bit is flipped.

The unit always returns a complete source register, even when only the low halves were compared. The first operand can be forced to the constant zero when its register specifier is zero. When the record flag is set, a four-bit condition field describes how the first operand orders against the second, and its write enable is raised. The bit after the three ordering flags copies the summary-overflow input. The result, the condition field and the enable are registered, so they appear one clock after the inputs.

Top module: `minmax_unit`

## Requirements
- R1: When `ra_zero_i` is 1, the value used for operand A, both for the comparison and as the returned source, is zero and `opa_i` has no effect.
- R2: With `mode_i` = 3'b000 the result is A if A is unsigned-less-than B, and B otherwise. With `mode_i` = 3'b001 the result is A if A is unsigned-greater-than B, and B otherwise.
- R3: `mode_i[1]` = 1 selects two's-complement signed ordering in place of unsigned ordering.
- R4: `mode_i[2]` = 1 (word mode) orders the operands by their low XLEN/2 bits only. The upper halves have no effect on which source is picked.
- R5: In word mode the result is still the whole original XLEN-bit source register, upper half included.
- R6: `mode_i[0]` = 1 selects the maximum. When the compared values are equal, both min and max return B.
- R7: When `rec_i` = 1, `cr_o` = {lt, gt, eq, `so_i`}, with lt in bit 3. The flags compare A against B under the chosen width and sign, and the max setting does not change them.
- R8: When `rec_i` = 0, `cr_we_o` is 0 and `cr_o` is 4'b0000. `cr_we_o` always equals the registered `rec_i`.
- R9: Outputs change on the first rising clock edge after the inputs are presented. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opa_i | input | XLEN | Operand A register value |
| opb_i | input | XLEN | Operand B register value |
| ra_zero_i | input | 1 | Operand A specifier is zero; use constant zero |
| mode_i | input | 3 | [2] word, [1] signed, [0] max |
| rec_i | input | 1 | Record flag: produce the condition field |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| res_o | output | XLEN | Selected source register |
| cr_o | output | 4 | Condition field {lt, gt, eq, so} |
| cr_we_o | output | 1 | Condition-field write enable |

## Verification
Suppose the operand conditioning is wrong, for example a sign bit that is not flipped or a half that is not shifted. The wrong source then appears on `res_o`, and usually the wrong ordering flag appears on `cr_o`, one clock after the faulty vector. Vectors whose upper and lower halves disagree expose these faults. So do vectors with mixed signs, vectors that tie, and vectors with the zero-operand flag set. A swap applied before the flags are formed shows up as lt and gt exchanged in max mode, while the result is still correct. The registered outputs are compared against an independent value model on every cycle, so a fault is reported on the cycle it first appears.

// File: rtl/mm_pkg.sv
package mm_pkg;

    // ordering of the conditioned operands
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } mm_order_t;

    // position of each control inside the mode field
    localparam int unsigned MODE_W     = 3;
    localparam int unsigned MODE_WORD  = 2;
    localparam int unsigned MODE_SIGN  = 1;
    localparam int unsigned MODE_MAX   = 0;
    localparam int unsigned CR_W       = 4;

endpackage

// File: rtl/mm_prep.sv
module mm_prep #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] val_i,
    input  logic            word_i,
    input  logic            sign_i,
    output logic [XLEN-1:0] key_o
);
    localparam int unsigned HALF = XLEN / 2;

    logic [XLEN-1:0] placed;

    generate
        if (HALF > 0) begin : g_half
            always_comb begin
                if (word_i) placed = {val_i[HALF-1:0], {(XLEN-HALF){1'b0}}};
                else        placed = val_i;
            end
        end else begin : g_nohalf
            always_comb placed = val_i;
        end
    endgenerate

    // flipping the top bit maps signed order onto unsigned order
    always_comb begin
        key_o           = placed;
        key_o[XLEN-1]   = placed[XLEN-1] ^ sign_i;
    end

endmodule

// File: rtl/mm_order.sv
module mm_order
    import mm_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] key_a_i,
    input  logic [XLEN-1:0] key_b_i,
    output mm_order_t       ord_o
);
    always_comb begin
        ord_o.lt = key_a_i < key_b_i;
        ord_o.eq = key_a_i == key_b_i;
        ord_o.gt = ~ord_o.lt & ~ord_o.eq;
    end

endmodule

// File: rtl/mm_pick.sv
module mm_pick
    import mm_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    input  mm_order_t       ord_i,
    input  logic            max_i,
    output logic [XLEN-1:0] res_o
);
    logic take_a;

    // swapping operands turns the less-than test into greater-than
    always_comb begin
        take_a = max_i ? ord_i.gt : ord_i.lt;
        res_o  = take_a ? src_a_i : src_b_i;
    end

endmodule

// File: rtl/minmax_unit.sv
module minmax_unit
    import mm_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    input  logic              ra_zero_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              rec_i,
    input  logic              so_i,
    output logic [XLEN-1:0]   res_o,
    output logic [CR_W-1:0]   cr_o,
    output logic              cr_we_o
);
    typedef struct packed {
        logic [XLEN-1:0] res;
        logic [CR_W-1:0] cr;
        logic            we;
    } mm_state_t;

    mm_state_t       st_d, st_q;
    logic [XLEN-1:0] src_a;
    logic [XLEN-1:0] key_a, key_b;
    logic [XLEN-1:0] pick_res;
    mm_order_t       ord;

    assign src_a = ra_zero_i ? '0 : opa_i;

    mm_prep #(.XLEN(XLEN)) prep_a_i (
        .val_i  (src_a),
        .word_i (mode_i[MODE_WORD]),
        .sign_i (mode_i[MODE_SIGN]),
        .key_o  (key_a)
    );

    mm_prep #(.XLEN(XLEN)) prep_b_i (
        .val_i  (opb_i),
        .word_i (mode_i[MODE_WORD]),
        .sign_i (mode_i[MODE_SIGN]),
        .key_o  (key_b)
    );

    mm_order #(.XLEN(XLEN)) order_i (
        .key_a_i (key_a),
        .key_b_i (key_b),
        .ord_o   (ord)
    );

    mm_pick #(.XLEN(XLEN)) pick_i (
        .src_a_i (src_a),
        .src_b_i (opb_i),
        .ord_i   (ord),
        .max_i   (mode_i[MODE_MAX]),
        .res_o   (pick_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = pick_res;
        st_d.we  = rec_i;
        st_d.cr  = rec_i ? {ord.lt, ord.gt, ord.eq, so_i} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o   = st_q.res;
    assign cr_o    = st_q.cr;
    assign cr_we_o = st_q.we;

endmodule

// File: rtl/minmax_unit_chk.sv
module minmax_unit_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] opa_i,
    input logic [XLEN-1:0] opb_i,
    input logic            ra_zero_i,
    input logic            rec_i,
    input logic            so_i,
    input logic [XLEN-1:0] res_o,
    input logic [3:0]      cr_o,
    input logic            cr_we_o
);
    logic [XLEN-1:0] a_eff;
    assign a_eff = ra_zero_i ? '0 : opa_i;

    // R1 R5
    result_is_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (res_o == $past(a_eff) || res_o == $past(opb_i)));

    // R6
    tie_takes_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_eff == opb_i) |=> (res_o == $past(opb_i)));

    // R8
    we_tracks_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cr_we_o == $past(rec_i)));

    // R8
    cr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_we_o |-> (cr_o == 4'b0000));

    // R7
    cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we_o |-> ($countones(cr_o[3:1]) == 1));

    // R7
    cr_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_i |=> (cr_o[0] == $past(so_i)));

endmodule

bind minmax_unit minmax_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .ra_zero_i (ra_zero_i),
    .rec_i     (rec_i),
    .so_i      (so_i),
    .res_o     (res_o),
    .cr_o      (cr_o),
    .cr_we_o   (cr_we_o)
);

// File: tb/minmax_unit_tb_top.sv
module minmax_unit_tb_top;
    localparam int unsigned XLEN = 64;
    localparam int unsigned HALF = XLEN / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] opa_i = '0;
    logic [XLEN-1:0] opb_i = '0;
    logic            ra_zero_i = 1'b0;
    logic [2:0]      mode_i = '0;
    logic            rec_i = 1'b0;
    logic            so_i = 1'b0;
    logic [XLEN-1:0] res_o;
    logic [3:0]      cr_o;
    logic            cr_we_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [XLEN-1:0] res;
        logic [3:0]      cr;
        logic            we;
        string           tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    minmax_unit #(.XLEN(XLEN)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .ra_zero_i (ra_zero_i),
        .mode_i    (mode_i),
        .rec_i     (rec_i),
        .so_i      (so_i),
        .res_o     (res_o),
        .cr_o      (cr_o),
        .cr_we_o   (cr_we_o)
    );

    function automatic exp_t model(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                   input logic z, input logic [2:0] m,
                                   input logic rec, input logic so, input string tag);
        exp_t e;
        logic [XLEN-1:0] av;
        logic lt, gt;
        av = z ? '0 : a;
        if (m[2]) begin
            if (m[1]) begin
                lt = $signed(av[HALF-1:0]) < $signed(b[HALF-1:0]);
                gt = $signed(av[HALF-1:0]) > $signed(b[HALF-1:0]);
            end else begin
                lt = av[HALF-1:0] < b[HALF-1:0];
                gt = av[HALF-1:0] > b[HALF-1:0];
            end
        end else begin
            if (m[1]) begin
                lt = $signed(av) < $signed(b);
                gt = $signed(av) > $signed(b);
            end else begin
                lt = av < b;
                gt = av > b;
            end
        end
        e.res = (m[0] ? gt : lt) ? av : b;
        e.cr  = rec ? {lt, gt, ~lt & ~gt, so} : 4'b0000;
        e.we  = rec;
        e.tag = tag;
        return e;
    endfunction

    task automatic apply(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input logic z, input logic [2:0] m,
                         input logic rec, input logic so, input string tag);
        @(negedge clk);
        opa_i = a; opb_i = b; ra_zero_i = z; mode_i = m; rec_i = rec; so_i = so;
        sb_q.push_back(model(a, b, z, m, rec, so, tag));
    endtask

    // monitor: compare one registered result per clock
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (res_o !== e.res || cr_o !== e.cr || cr_we_o !== e.we) begin
                n_bad++;
                $display("FAIL %s: res=%h cr=%b we=%b expected res=%h cr=%b we=%b",
                         e.tag, res_o, cr_o, cr_we_o, e.res, e.cr, e.we);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        opa_i = 64'hDEAD_BEEF_0000_0001;
        opb_i = 64'h1;
        rec_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        n_chk++;
        if (res_o !== '0 || cr_o !== 4'b0 || cr_we_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset: res=%h cr=%b we=%b expected all zero", res_o, cr_o, cr_we_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 unsigned doubleword min and max
        apply(64'd5, 64'd9, 1'b0, 3'b000, 1'b0, 1'b0, "R2 umin");
        apply(64'd5, 64'd9, 1'b0, 3'b001, 1'b0, 1'b0, "R2 umax");
        apply(64'hFFFF_FFFF_FFFF_FFF0, 64'd3, 1'b0, 3'b000, 1'b1, 1'b0, "R2 umin big");
        // R3 signed ordering
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 3'b010, 1'b0, 1'b0, "R3 smin");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 3'b011, 1'b1, 1'b0, "R3 smax");
        apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 3'b010, 1'b1, 1'b0, "R3 extremes");
        // R1 zero operand
        apply(64'h55, 64'd3, 1'b1, 3'b000, 1'b1, 1'b0, "R1 zero umin");
        apply(64'h55, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 3'b010, 1'b1, 1'b0, "R1 zero smin");
        apply(64'h55, 64'd3, 1'b1, 3'b001, 1'b0, 1'b0, "R1 zero umax");
        // R4 R5 word mode, upper halves disagree with lower
        apply(64'hFFFF_0000_0000_0002, 64'h0000_0001_0000_0003, 1'b0, 3'b100, 1'b1, 1'b0, "R4 R5 word umin");
        apply(64'hFFFF_0000_0000_0002, 64'h0000_0001_0000_0003, 1'b0, 3'b101, 1'b1, 1'b0, "R4 R5 word umax");
        apply(64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b0, 3'b110, 1'b1, 1'b0, "R4 word smin");
        apply(64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 1'b0, 3'b111, 1'b1, 1'b0, "R4 word smax");
        // R6 ties return B
        apply(64'h1111_0000_0000_0007, 64'h2222_0000_0000_0007, 1'b0, 3'b100, 1'b1, 1'b0, "R6 tie word min");
        apply(64'h1111_0000_0000_0007, 64'h2222_0000_0000_0007, 1'b0, 3'b101, 1'b1, 1'b0, "R6 tie word max");
        apply(64'd42, 64'd42, 1'b0, 3'b011, 1'b1, 1'b1, "R6 tie smax");
        // R7 flags in max mode and so copy
        apply(64'd1, 64'd2, 1'b0, 3'b001, 1'b1, 1'b1, "R7 max lt so");
        apply(64'd9, 64'd2, 1'b0, 3'b001, 1'b1, 1'b0, "R7 max gt");
        // R8 record clear
        apply(64'd1, 64'd2, 1'b0, 3'b000, 1'b0, 1'b1, "R8 no record");
        // random sweep
        for (int i = 0; i < 400; i++) begin
            logic [XLEN-1:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 7 == 0) b[HALF-1:0] = a[HALF-1:0];
            if (i % 11 == 0) b = a;
            apply(a, b, ($urandom % 8) == 0, 3'($urandom), 1'($urandom), 1'($urandom), "R2 R3 R4 R7 random");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule